// File: doc/BRIEF.md
# Host Receive Packet Queue with In-Band Status

This block buffers inbound packets for a host channel in one shared word queue. Every accepted packet goes in as a tagged status word followed by its payload as 32-bit words. The status word carries the channel, the byte count, the data PID and a packet-status code. When a transfer ends, the producer pushes one more tagged status word with a different code. This word marks completion in-band, behind the last payload.

Software works from the head of the queue. It looks at the head word without removing it, then pops. A level interrupt tells it that a status word is waiting at the head, and software can mask it while it drains payload. Popping the completion word produces a one-cycle transfer-complete pulse. A remaining-packet counter, loaded when the transfer is armed, then tells software how to proceed: a nonzero count means the channel must be halted, and zero means it can be re-armed.

A packet whose header shows that it cannot fit in the free space is refused as a whole, and an error flag records the refusal.

Top module: `rxfifo_status`

## Requirements
- R1: An accepted packet is stored as one status word (tag set) followed by ceil(bytes/4) payload words (tag clear). The status word holds channel in [3:0], byte count in [14:4], PID in [16:15], packet status 4'b0010 in [20:17], and zeros in [31:21].
- R2: A packet stays invisible at the read side (`rdValid` stays low on an otherwise empty queue) until its last payload word has been written. A zero-byte packet becomes visible in the cycle after its header.
- R3: A completion request stores one tagged status word with the given channel and code in [20:17], and zero byte count and PID.
- R4: `rxLevelIrq` is high exactly while the head entry is a status word and the mask is low.
- R5: While `rxMask` is high, `rxLevelIrq` stays low.
- R6: `rdWord`/`rdIsStatus` show the head entry without consuming it. `popReq` removes the head. A pop on an empty queue changes nothing.
- R7: `xferCmplIrq` pulses for exactly one cycle, in the cycle after a status word whose code is not 4'b0010 is popped. Popping data-status or payload words never raises it.
- R8: `armValid` loads `pktRemain`. Each pop of a data-status word (code 4'b0010) decrements it, stopping at zero. Other pops leave it unchanged.
- R9: A packet needing more words (1 + payload) than are free is dropped whole, including its payload words, and `babbleErr` is set. Later packets that fit are stored normally. `armValid` clears `babbleErr`.
- R10: After reset the queue is empty, both interrupts are low, `pktRemain` is 0 and `babbleErr` is 0.
- R11: At default parameters, one 1024-byte packet with its status word fits without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hdrValid | input | 1 | Packet header offered (between packets only) |
| hdrChan | input | 4 | Header channel number |
| hdrBytes | input | 11 | Header byte count |
| hdrPid | input | 2 | Header data PID |
| dataValid | input | 1 | Payload word offered |
| dataWord | input | 32 | Payload word |
| cmplValid | input | 1 | Completion entry request |
| cmplChan | input | 4 | Completion channel number |
| cmplCode | input | 4 | Completion packet-status code |
| armValid | input | 1 | Load remaining packet count, clear error |
| armPktCnt | input | PCW | Packets expected in the transfer |
| rxMask | input | 1 | Level-interrupt mask |
| popReq | input | 1 | Remove the head entry |
| rdValid | output | 1 | Head entry present |
| rdIsStatus | output | 1 | Head entry is a status word |
| rdWord | output | 32 | Head entry contents |
| rxLevelIrq | output | 1 | Status word waiting at head |
| xferCmplIrq | output | 1 | Completion entry was just popped |
| pktRemain | output | PCW | Remaining packet count |
| babbleErr | output | 1 | A packet or completion entry was refused |

## Verification
The assertions assume that headers and completion requests arrive only between packets, never in the same cycle. They also assume that payload words arrive only while a packet is open, and that a completion code never equals 4'b0010. The bench drives each packet and completion from one serial task, and issues a new header only after the previous packet's last payload word. The completion codes it uses are 4'b0011 and 4'b0111. Pops are issued from a separate task while no write is in progress, so read-side checks never overlap a commit.

// File: rtl/rxfifo_pkg.sv
package rxfifo_pkg;
  localparam int WORD_W = 32;
  localparam logic [3:0] PKT_DATA = 4'b0010;

  typedef struct packed {
    logic wrEn;
    logic wrTag;
    logic commit;
    logic pop;
  } fifoStrb_t;

  function automatic logic [WORD_W-1:0] mkStatus(logic [3:0] ch, logic [10:0] bc,
                                                  logic [1:0] pid, logic [3:0] sts);
    return {11'b0, sts, pid, bc, ch};
  endfunction
endpackage

// File: rtl/rxfifo_dpath.sv
module rxfifo_dpath
  import rxfifo_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrb_t         strb,
  input  logic [WORD_W-1:0] wrWord,
  output logic [ADDR_W:0]   freeWords,
  output logic              headValid,
  output logic              headTag,
  output logic [WORD_W-1:0] headWord
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW = ADDR_W + 1;

  logic [WORD_W:0] mem [DEPTH];
  logic [PW-1:0] wrShadow, wrPtr, rdPtr;
  logic [PW-1:0] shadowNext;

  assign shadowNext = wrShadow + PW'(strb.wrEn);

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[wrShadow[ADDR_W-1:0]] <= {strb.wrTag, wrWord};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrShadow <= '0;
      wrPtr    <= '0;
      rdPtr    <= '0;
    end else begin
      wrShadow <= shadowNext;
      if (strb.commit) wrPtr <= shadowNext;
      if (strb.pop) rdPtr <= rdPtr + PW'(1);
    end
  end

  assign freeWords = PW'(DEPTH) - (wrShadow - rdPtr);
  assign headValid = wrPtr != rdPtr;
  assign {headTag, headWord} = mem[rdPtr[ADDR_W-1:0]];
endmodule

// File: rtl/rxfifo_ctrl.sv
module rxfifo_ctrl
  import rxfifo_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PCW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hdrValid,
  input  logic [3:0]        hdrChan,
  input  logic [10:0]       hdrBytes,
  input  logic [1:0]        hdrPid,
  input  logic              dataValid,
  input  logic [WORD_W-1:0] dataWord,
  input  logic              cmplValid,
  input  logic [3:0]        cmplChan,
  input  logic [3:0]        cmplCode,
  input  logic              armValid,
  input  logic [PCW-1:0]    armPktCnt,
  input  logic              popReq,
  input  logic [ADDR_W:0]   freeWords,
  input  logic              headValid,
  input  logic              headTag,
  input  logic [3:0]        headSts,
  output fifoStrb_t         strb,
  output logic [WORD_W-1:0] wrWord,
  output logic [PCW-1:0]    pktRemain,
  output logic              babbleErr,
  output logic              xferPulse
);
  logic [9:0]  wordsLeft;
  logic        dropping;
  logic [11:0] roundUp;
  logic [9:0]  hdrWords;
  logic        idle, hdrFire, hdrFits, hdrAccept, hdrDrop;
  logic        cmplFire, cmplFits, dataStsPop;

  assign roundUp   = {1'b0, hdrBytes} + 12'd3;
  assign hdrWords  = roundUp[11:2];
  assign idle      = wordsLeft == '0;
  assign hdrFire   = hdrValid && idle;
  assign hdrFits   = (32'(hdrWords) + 32'd1) <= 32'(freeWords);
  assign hdrAccept = hdrFire && hdrFits;
  assign hdrDrop   = hdrFire && !hdrFits;
  assign cmplFire  = cmplValid && idle && !hdrValid;
  assign cmplFits  = freeWords != '0;
  assign dataStsPop = strb.pop && headTag && headSts == PKT_DATA;

  always_comb begin
    strb   = '0;
    wrWord = dataWord;
    if (hdrAccept) begin
      strb.wrEn   = 1'b1;
      strb.wrTag  = 1'b1;
      strb.commit = hdrWords == '0;
      wrWord      = mkStatus(hdrChan, hdrBytes, hdrPid, PKT_DATA);
    end else if (dataValid && !idle && !dropping) begin
      strb.wrEn   = 1'b1;
      strb.commit = wordsLeft == 10'd1;
    end else if (cmplFire && cmplFits) begin
      strb.wrEn   = 1'b1;
      strb.wrTag  = 1'b1;
      strb.commit = 1'b1;
      wrWord      = mkStatus(cmplChan, 11'd0, 2'd0, cmplCode);
    end
    strb.pop = popReq && headValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordsLeft <= '0;
      dropping  <= 1'b0;
      babbleErr <= 1'b0;
      pktRemain <= '0;
      xferPulse <= 1'b0;
    end else begin
      xferPulse <= strb.pop && headTag && headSts != PKT_DATA;
      if (hdrFire) begin
        wordsLeft <= hdrWords;
        dropping  <= hdrDrop && hdrWords != '0;
      end else if (dataValid && !idle) begin
        wordsLeft <= wordsLeft - 10'd1;
        if (wordsLeft == 10'd1) dropping <= 1'b0;
      end
      if (hdrDrop || (cmplFire && !cmplFits)) babbleErr <= 1'b1;
      else if (armValid) babbleErr <= 1'b0;
      if (armValid) pktRemain <= armPktCnt;
      else if (dataStsPop && pktRemain != '0) pktRemain <= pktRemain - PCW'(1);
    end
  end
endmodule

// File: rtl/rxfifo_status.sv
module rxfifo_status
  import rxfifo_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PCW = 10
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           hdrValid,
  input  logic [3:0]     hdrChan,
  input  logic [10:0]    hdrBytes,
  input  logic [1:0]     hdrPid,
  input  logic           dataValid,
  input  logic [31:0]    dataWord,
  input  logic           cmplValid,
  input  logic [3:0]     cmplChan,
  input  logic [3:0]     cmplCode,
  input  logic           armValid,
  input  logic [PCW-1:0] armPktCnt,
  input  logic           rxMask,
  input  logic           popReq,
  output logic           rdValid,
  output logic           rdIsStatus,
  output logic [31:0]    rdWord,
  output logic           rxLevelIrq,
  output logic           xferCmplIrq,
  output logic [PCW-1:0] pktRemain,
  output logic           babbleErr
);
  fifoStrb_t         strb;
  logic [WORD_W-1:0] wrWord;
  logic [ADDR_W:0]   freeWords;
  logic              headValid, headTag;
  logic [WORD_W-1:0] headWord;

  rxfifo_ctrl #(.ADDR_W(ADDR_W), .PCW(PCW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .hdrValid(hdrValid), .hdrChan(hdrChan), .hdrBytes(hdrBytes), .hdrPid(hdrPid),
    .dataValid(dataValid), .dataWord(dataWord),
    .cmplValid(cmplValid), .cmplChan(cmplChan), .cmplCode(cmplCode),
    .armValid(armValid), .armPktCnt(armPktCnt), .popReq(popReq),
    .freeWords(freeWords), .headValid(headValid), .headTag(headTag),
    .headSts(headWord[20:17]),
    .strb(strb), .wrWord(wrWord), .pktRemain(pktRemain),
    .babbleErr(babbleErr), .xferPulse(xferCmplIrq)
  );

  rxfifo_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrWord(wrWord),
    .freeWords(freeWords), .headValid(headValid), .headTag(headTag),
    .headWord(headWord)
  );

  assign rdValid    = headValid;
  assign rdIsStatus = headValid && headTag;
  assign rdWord     = headWord;
  assign rxLevelIrq = rdIsStatus && !rxMask;
endmodule

// File: rtl/rxfifo_status_chk.sv
module rxfifo_status_chk #(
  parameter int PCW = 10
) (
  input logic           clk,
  input logic           rstN,
  input logic           hdrValid,
  input logic           cmplValid,
  input logic           armValid,
  input logic           rxMask,
  input logic           popReq,
  input logic           rdValid,
  input logic           rdIsStatus,
  input logic [31:0]    rdWord,
  input logic           rxLevelIrq,
  input logic           xferCmplIrq,
  input logic [PCW-1:0] pktRemain,
  input logic           babbleErr
);
  AST_IRQ_AT_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    rxLevelIrq |-> rdValid && rdIsStatus); // R4
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    rxMask |-> !rxLevelIrq); // R5
  AST_CMPL_AFTER_POP: assert property (@(posedge clk) disable iff (!rstN)
    xferCmplIrq |-> $past(popReq && rdValid && rdIsStatus && rdWord[20:17] != 4'b0010)); // R7
  AST_NO_CMPL_ON_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && rdValid && !(rdIsStatus && rdWord[20:17] != 4'b0010)) |=> !xferCmplIrq); // R7
  AST_REMAIN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!armValid && popReq && rdValid && rdIsStatus && rdWord[20:17] == 4'b0010 && pktRemain != '0)
      |=> pktRemain == $past(pktRemain) - PCW'(1)); // R8
  AST_REMAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!armValid && !(popReq && rdValid)) |=> $stable(pktRemain)); // R8
  AST_BABBLE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (armValid && !hdrValid && !cmplValid) |=> !babbleErr); // R9
endmodule

bind rxfifo_status rxfifo_status_chk #(.PCW(PCW)) u_chk (
  .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .cmplValid(cmplValid),
  .armValid(armValid), .rxMask(rxMask), .popReq(popReq), .rdValid(rdValid),
  .rdIsStatus(rdIsStatus), .rdWord(rdWord), .rxLevelIrq(rxLevelIrq),
  .xferCmplIrq(xferCmplIrq), .pktRemain(pktRemain), .babbleErr(babbleErr)
);

// File: tb/test_rxfifo_status.sv
module test_rxfifo_status;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 5;
  localparam int CAP = 1 << ADDR_W;
  localparam int PCW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hdrValid = 1'b0, dataValid = 1'b0, cmplValid = 1'b0, armValid = 1'b0;
  logic rxMask = 1'b0, popReq = 1'b0;
  logic [3:0] hdrChan = '0, cmplChan = '0, cmplCode = '0;
  logic [10:0] hdrBytes = '0;
  logic [1:0] hdrPid = '0;
  logic [31:0] dataWord = '0;
  logic [PCW-1:0] armPktCnt = '0;

  logic rdValid, rdIsStatus, rxLevelIrq, xferCmplIrq, babbleErr;
  logic [31:0] rdWord;
  logic [PCW-1:0] pktRemain;
  logic bigValid, bigIsStatus, bigIrq, bigCmpl, bigBabble;
  logic [31:0] bigWord;
  logic [PCW-1:0] bigRemain;

  int vectors = 0;
  int miscompares = 0;
  int expRemain = 0;
  logic [32:0] expQ[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  rxfifo_status #(.ADDR_W(ADDR_W), .PCW(PCW)) i_rxfifo_status (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .hdrChan(hdrChan), .hdrBytes(hdrBytes),
    .hdrPid(hdrPid), .dataValid(dataValid), .dataWord(dataWord), .cmplValid(cmplValid),
    .cmplChan(cmplChan), .cmplCode(cmplCode), .armValid(armValid), .armPktCnt(armPktCnt),
    .rxMask(rxMask), .popReq(popReq), .rdValid(rdValid), .rdIsStatus(rdIsStatus),
    .rdWord(rdWord), .rxLevelIrq(rxLevelIrq), .xferCmplIrq(xferCmplIrq),
    .pktRemain(pktRemain), .babbleErr(babbleErr)
  );

  rxfifo_status #(.PCW(PCW)) i_rxfifo_status_dflt (
    .clk(clk), .rstN(rstN), .hdrValid(hdrValid), .hdrChan(hdrChan), .hdrBytes(hdrBytes),
    .hdrPid(hdrPid), .dataValid(dataValid), .dataWord(dataWord), .cmplValid(cmplValid),
    .cmplChan(cmplChan), .cmplCode(cmplCode), .armValid(armValid), .armPktCnt(armPktCnt),
    .rxMask(rxMask), .popReq(popReq), .rdValid(bigValid), .rdIsStatus(bigIsStatus),
    .rdWord(bigWord), .rxLevelIrq(bigIrq), .xferCmplIrq(bigCmpl),
    .pktRemain(bigRemain), .babbleErr(bigBabble)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stsWord(logic [3:0] ch, logic [10:0] bc, logic [1:0] pid,
                                          logic [3:0] sts);
    return {11'b0, sts, pid, bc, ch};
  endfunction

  // Driver: sends one packet, predicts acceptance from free space
  task automatic sendPacket(logic [3:0] ch, logic [10:0] bytes, logic [1:0] pid);
    int words = (int'(bytes) + 3) / 4;
    bit fits = (words + 1) <= (CAP - expQ.size());
    bit wasEmpty = expQ.size() == 0;
    if (fits) expQ.push_back({1'b1, stsWord(ch, bytes, pid, 4'b0010)});
    hdrValid = 1'b1; hdrChan = ch; hdrBytes = bytes; hdrPid = pid;
    tick();
    hdrValid = 1'b0;
    if (wasEmpty && words > 0) chk("R2 hidden before payload", 64'(rdValid), 64'd0);
    for (int i = 0; i < words; i++) begin
      dataValid = 1'b1;
      dataWord = 32'hC000_0000 | (32'(bytes) << 12) | 32'(i);
      if (fits) expQ.push_back({1'b0, dataWord});
      tick();
      if (wasEmpty && fits && i < words - 1) chk("R2 hidden mid packet", 64'(rdValid), 64'd0);
    end
    dataValid = 1'b0;
  endtask

  task automatic sendCmpl(logic [3:0] ch, logic [3:0] code);
    expQ.push_back({1'b1, stsWord(ch, 11'd0, 2'd0, code)});
    cmplValid = 1'b1; cmplChan = ch; cmplCode = code;
    tick();
    cmplValid = 1'b0;
  endtask

  task automatic arm(int cnt);
    armValid = 1'b1; armPktCnt = PCW'(cnt);
    tick();
    armValid = 1'b0;
    expRemain = cnt;
  endtask

  // Monitor: pops one entry and compares it against the scoreboard
  task automatic popOne();
    logic [32:0] e = expQ.pop_front();
    bit isData = e[32] && e[20:17] == 4'b0010;
    bit isCmpl = e[32] && e[20:17] != 4'b0010;
    chk("R6 head valid", 64'(rdValid), 64'd1);
    chk("R1/R3 head entry", {31'b0, rdIsStatus, rdWord}, {31'b0, e});
    chk("R4 level irq", 64'(rxLevelIrq), 64'(e[32]));
    popReq = 1'b1;
    tick();
    popReq = 1'b0;
    if (isData && expRemain > 0) expRemain--;
    chk("R8 remaining count", 64'(pktRemain), 64'(expRemain));
    chk("R7 completion pulse", 64'(xferCmplIrq), 64'(isCmpl));
    if (isCmpl) begin
      tick();
      chk("R7 pulse one cycle", 64'(xferCmplIrq), 64'd0);
    end
  endtask

  task automatic drain();
    while (expQ.size() > 0) popOne();
    chk("R6 empty after drain", 64'(rdValid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    tick(); tick();
    rstN = 1'b1;
    tick();
    // R10 reset state
    chk("R10 empty", 64'(rdValid), 64'd0);
    chk("R10 level irq", 64'(rxLevelIrq), 64'd0);
    chk("R10 cmpl irq", 64'(xferCmplIrq), 64'd0);
    chk("R10 remain", 64'(pktRemain), 64'd0);
    chk("R10 babble", 64'(babbleErr), 64'd0);

    // R11 default capacity; small instance refuses the same packet (R9)
    sendPacket(4'd1, 11'd1024, 2'd0);
    chk("R11 no error at default size", 64'(bigBabble), 64'd0);
    chk("R11 status at head", {bigIsStatus, bigWord}, {1'b1, stsWord(4'd1, 11'd1024, 2'd0, 4'b0010)});
    chk("R9 oversize dropped", 64'(rdValid), 64'd0);
    chk("R9 babble set", 64'(babbleErr), 64'd1);
    for (int i = 0; i < 257; i++) begin
      popReq = 1'b1;
      tick();
    end
    popReq = 1'b0;
    chk("R11 big drained", 64'(bigValid), 64'd0);
    chk("R6 empty pop ignored", 64'(rdValid), 64'd0);

    arm(3);
    chk("R9 arm clears babble", 64'(babbleErr), 64'd0);
    chk("R8 arm loads", 64'(pktRemain), 64'd3);

    // R1/R2/R4/R5/R6 normal packet
    sendPacket(4'd2, 11'd10, 2'd1);
    chk("R2 visible after last word", 64'(rdValid), 64'd1);
    chk("R4 irq raised", 64'(rxLevelIrq), 64'd1);
    tick(); tick();
    chk("R6 peek stable", {rdIsStatus, rdWord}, {1'b1, stsWord(4'd2, 11'd10, 2'd1, 4'b0010)});
    rxMask = 1'b1;
    tick();
    chk("R5 masked", 64'(rxLevelIrq), 64'd0);
    rxMask = 1'b0;
    tick();
    drain();

    // R1/R2 zero-byte packet, then completion with remaining count nonzero (R3/R7/R8)
    sendPacket(4'd2, 11'd0, 2'd2);
    chk("R2 zero byte visible", 64'(rdValid), 64'd1);
    sendCmpl(4'd2, 4'b0011);
    drain();
    chk("R8 incomplete count", 64'(pktRemain), 64'd1);

    // R9 overflow mid-stream: fits, dropped, fits
    arm(2);
    sendPacket(4'd5, 11'd100, 2'd0);
    sendPacket(4'd5, 11'd40, 2'd1);
    chk("R9 babble on overflow", 64'(babbleErr), 64'd1);
    sendPacket(4'd5, 11'd7, 2'd3);
    drain();
    chk("R8 remain zero", 64'(pktRemain), 64'd0);

    // R8 saturation at zero, and completion with another code
    sendPacket(4'd9, 11'd4, 2'd0);
    sendCmpl(4'd9, 4'b0111);
    drain();
    chk("R8 saturated", 64'(pktRemain), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule